// File: doc/BRIEF.md
# Transformer Fault Sequencer

This block is the protection and fault-latching sequencer for an electronic transformer controller that drives a self-oscillating push-pull stage. It does not sense any analog value. Comparator results for overload, overtemperature, overvoltage and the zero-crossing window arrive as digital flags. A one-cycle time-base pulse arrives every 250 µs. A mode bit says whether the supply is AC or DC, and two flags report that the supply is below 6 V or above 8 V.

From these inputs the block decides when the external trigger pulses must be blocked and when the oscillator must be stopped.

- **Overload and overtemperature** are qualified by a shared enquiry cycle. A first hit starts a long delay, and only a second hit after the delay is accepted. An accepted fault is latched until the supply collapses. In AC mode the overload flag is blanked around each zero crossing.
- **Overvoltage** works differently. After a short persistence filter it forces the switching transistor on for a few time-base periods. It also blocks triggers for a fixed interval, and then clears itself.
- **Power-down.** When the supply drops below 6 V, all state is cleared and held clear until the supply is reported above 8 V again.

Top module: `fault_sequencer`

## Requirements
- R1: After reset all outputs are low.
- R2: The first overload or overtemperature seen while idle starts a delay of DLY_TICKS time-base pulses, counted from the next clock. No fault is latched before the DLY_TICKS-th pulse has been taken, even if the flag stays high the whole time.
- R3: After the delay the block waits for a second hit until the next time-base pulse is taken.
  - An overload in that window latches the overload fault.
  - With no hit in that window the sequencer returns to idle, and a later hit only starts a new delay.
- R4: With `ac_mode`=1 the overload flag is ignored in three cases: while `zc_win`=1, in the clock where `zc_win` falls, and until BLANK_TICKS further time-base pulses have been taken. With `ac_mode`=0 it is never blanked.
- R5: Overtemperature runs through the same enquiry as overload, is never blanked, and latches `ot_fault` instead of `ol_fault`.
- R6: A latched fault drives `lp_fault`=1, `trig_gate`=1 (1 means triggers are blocked) and `turnoff`=1, and holds them whatever the fault inputs do afterwards.
- R7: `sup_lo`=1 drops `turnoff` at once and clears every latch and timer at the next clock. All outputs then stay low, and all flags are ignored, until a clock with `sup_ok`=1 and `sup_lo`=0.
- R8: An overvoltage response starts only after `ov_flag`=1 has been sampled on OV_FILT_CYC consecutive clocks with `zc_win`=0.
- R9: On an overvoltage response `sw_force` goes high and stays high until the FORCE_TICKS-th time-base pulse after the response has been taken.
- R10: An overvoltage response raises `ov_active` and `trig_gate` for OV_TICKS time-base pulses, after which both clear by themselves.
- R11: Overvoltage confined to the zero-crossing window is ignored. Overvoltage that outlasts the window starts its filter when the window ends.
- R12: While a fault is latched, `sw_force` stays low even during an overvoltage response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse every 250 µs time-base period |
| ac_mode | input | 1 | 1 = AC supply detected, 0 = DC |
| zc_win | input | 1 | High while the zero-crossing window is open |
| ol_flag | input | 1 | Overload comparator output |
| ot_flag | input | 1 | Overtemperature comparator output |
| ov_flag | input | 1 | Overvoltage comparator output |
| sup_lo | input | 1 | Supply below 6 V |
| sup_ok | input | 1 | Supply above 8 V |
| trig_gate | output | 1 | 1 = trigger pulses blocked |
| turnoff | output | 1 | Static turn-off request |
| sw_force | output | 1 | Force the switching transistor on (overvoltage) |
| lp_fault | output | 1 | Latched fault, low-power state |
| ol_fault | output | 1 | Overload fault latched |
| ot_fault | output | 1 | Overtemperature fault latched |
| ov_active | output | 1 | Overvoltage blanking interval running |

## Verification
The embedded properties check several things on every cycle:
- a fault only rises out of the re-check state;
- a latched fault keeps triggers blocked and never coexists with a forced switch;
- power-down keeps the outputs quiet;
- a zero-crossing window in AC mode never starts an enquiry;
- every overvoltage response follows a sampled overvoltage outside the window.

The exact length of the enquiry delay, the blanking and forcing intervals, and the persistence filter threshold can only be shown by the bench's timed scenarios. The same holds for whether a blanked overload left the sequencer idle. The bench infers that from the timing of a later hit.

// File: rtl/fault_sequencer.sv
module fault_sequencer #(
  parameter int DLY_TICKS   = 4096,
  parameter int BLANK_TICKS = 5,
  parameter int OV_TICKS    = 50,
  parameter int FORCE_TICKS = 3,
  parameter int OV_FILT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ac_mode,
  input  logic zc_win,
  input  logic ol_flag,
  input  logic ot_flag,
  input  logic ov_flag,
  input  logic sup_lo,
  input  logic sup_ok,
  output logic trig_gate,
  output logic turnoff,
  output logic sw_force,
  output logic lp_fault,
  output logic ol_fault,
  output logic ot_fault,
  output logic ov_active
);

  localparam int DW = $clog2(DLY_TICKS + 1);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int OW = $clog2(OV_TICKS + 1);
  localparam int FW = $clog2(FORCE_TICKS + 1);
  localparam int CW = $clog2(OV_FILT_CYC + 1);
  localparam logic [DW-1:0] DLY_LAST  = DW'(DLY_TICKS - 1);
  localparam logic [CW-1:0] FILT_LAST = CW'(OV_FILT_CYC - 1);
  localparam logic [CW-1:0] FILT_MAX  = CW'(OV_FILT_CYC);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CHECK} enq_t;

  enq_t          st;
  logic [DW-1:0] dcnt;
  logic [BW-1:0] bcnt;
  logic [OW-1:0] ovcnt;
  logic [FW-1:0] frcnt;
  logic [CW-1:0] fcnt;
  logic          pwr_dn, zc_d;
  logic          clr, zc_fall, blank, ol_q, ov_ok, ov_evt;

  assign clr     = sup_lo | pwr_dn;
  assign zc_fall = zc_d & ~zc_win;
  assign blank   = ac_mode & (zc_win | zc_fall | (bcnt != '0));
  assign ol_q    = ol_flag & ~blank;
  assign ov_ok   = ov_flag & ~zc_win;
  assign ov_evt  = ov_ok & (fcnt == FILT_LAST);

  assign lp_fault  = ol_fault | ot_fault;
  assign turnoff   = lp_fault & ~sup_lo;
  assign ov_active = ovcnt != '0;
  assign trig_gate = lp_fault | ov_active;
  assign sw_force  = (frcnt != '0) & ~lp_fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pwr_dn <= 1'b0;
    else if (clr) pwr_dn <= sup_lo | ~sup_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       begin zc_d <= 1'b0; bcnt <= '0; end
    else if (clr)     begin zc_d <= 1'b0; bcnt <= '0; end
    else begin
      zc_d <= zc_win;
      if (ac_mode && zc_fall)        bcnt <= BW'(BLANK_TICKS);
      else if (tick && bcnt != '0)   bcnt <= bcnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; ol_fault <= 1'b0; ot_fault <= 1'b0;
    end else if (clr) begin
      st <= S_IDLE; dcnt <= '0; ol_fault <= 1'b0; ot_fault <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (!lp_fault && (ol_q || ot_flag)) begin
            st   <= S_WAIT;
            dcnt <= '0;
          end
        S_WAIT:
          if (tick) begin
            if (dcnt == DLY_LAST) st <= S_CHECK;
            else                  dcnt <= dcnt + 1'b1;
          end
        S_CHECK:
          if (ol_q || ot_flag) begin
            ol_fault <= ol_q;
            ot_fault <= ot_flag;
            st       <= S_IDLE;
          end else if (tick) begin
            st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      fcnt <= '0;
    else if (clr)    fcnt <= '0;
    else if (!ov_ok) fcnt <= '0;
    else if (fcnt != FILT_MAX) fcnt <= fcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  begin ovcnt <= '0; frcnt <= '0; end
    else if (clr) begin ovcnt <= '0; frcnt <= '0; end
    else if (ov_evt) begin
      ovcnt <= OW'(OV_TICKS);
      frcnt <= FW'(FORCE_TICKS);
    end else if (tick) begin
      if (ovcnt != '0) ovcnt <= ovcnt - 1'b1;
      if (frcnt != '0) frcnt <= frcnt - 1'b1;
    end

  AST_FAULT_FROM_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_fault) |-> $past(st) == S_CHECK); // R3

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fault |-> trig_gate && (turnoff || sup_lo)); // R6

  AST_NO_FORCE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fault |-> !sw_force); // R12

  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !trig_gate && !sw_force && !turnoff); // R7

  AST_AC_ZC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ac_mode && zc_win && !ot_flag && !clr) |=> st == S_IDLE); // R4

  AST_OV_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_active) |-> $past(ov_flag) && !$past(zc_win)); // R8

  AST_FORCE_IN_OV: assert property (@(posedge clk) disable iff (!rst_n)
    sw_force |-> ov_active); // R10

endmodule

// File: tb/test_fault_sequencer.sv
`timescale 1ns/1ps
module test_fault_sequencer;
  localparam int DLY = 64, BLK = 5, OVT = 10, FRC = 3, FILT = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ac_mode = 1'b0, zc_win = 1'b0, ol_flag = 1'b0, ot_flag = 1'b0, ov_flag = 1'b0;
  logic sup_lo = 1'b0, sup_ok = 1'b0;
  logic trig_gate, turnoff, sw_force, lp_fault, ol_fault, ot_fault, ov_active;
  int n_tests = 0, n_fail = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= (tdiv == 7) ? 0 : tdiv + 1;
    tick <= (tdiv == 7);
  end

  fault_sequencer #(.DLY_TICKS(DLY), .BLANK_TICKS(BLK), .OV_TICKS(OVT),
                    .FORCE_TICKS(FRC), .OV_FILT_CYC(FILT)) i_fault_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ac_mode(ac_mode), .zc_win(zc_win),
    .ol_flag(ol_flag), .ot_flag(ot_flag), .ov_flag(ov_flag), .sup_lo(sup_lo),
    .sup_ok(sup_ok), .trig_gate(trig_gate), .turnoff(turnoff), .sw_force(sw_force),
    .lp_fault(lp_fault), .ol_fault(ol_fault), .ot_fault(ot_fault), .ov_active(ov_active));

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n, input bit now);
    int c = 0;
    if (n == 0) return;
    if (!now) @(negedge clk);
    forever begin
      if (tick) begin
        c++;
        if (c == n) break;
      end
      @(negedge clk);
    end
  endtask

  task automatic ol_start(input int n);
    ol_flag = 1'b1;
    @(negedge clk);
    ol_flag = 1'b0;
    wait_ticks(n, 1'b1);
  endtask

  task automatic ol_pulse();
    ol_flag = 1'b1;
    @(negedge clk);
    ol_flag = 1'b0;
  endtask

  task automatic pcycle();
    sup_lo = 1'b1;
    repeat (2) @(negedge clk);
    sup_lo = 1'b0;
    @(negedge clk);
    sup_ok = 1'b1;
    @(negedge clk);
    sup_ok = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic exp_fault_after_blank(input logic ac, input int k);
    return !(ac && k <= BLK);
  endfunction

  function automatic logic exp_ov(input int len);
    return len >= FILT;
  endfunction

  task automatic blank_trial(input logic ac, input int k);
    pcycle();
    ac_mode = ac;
    zc_win = 1'b1;
    repeat (3) @(negedge clk);
    zc_win = 1'b0;
    wait_ticks(k, 1'b0);
    ol_start(DLY + 1);
    ol_pulse();
    chk(ac ? "R4 ac blank" : "R4 dc no blank", lp_fault, exp_fault_after_blank(ac, k));
    ac_mode = 1'b0;
  endtask

  task automatic ov_trial(input int len);
    ov_flag = 1'b1;
    repeat (len) @(negedge clk);
    ov_flag = 1'b0;
    @(negedge clk);
    chk("R8 ov filter", ov_active, exp_ov(len));
    wait_ticks(OVT + 1, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 trig_gate", trig_gate, 1'b0);
    chk("R1 turnoff", turnoff, 1'b0);
    chk("R1 sw_force", sw_force, 1'b0);
    chk("R1 lp_fault", lp_fault, 1'b0);
    chk("R1 ov_active", ov_active, 1'b0);

    // R2 / R6: overload held high through the whole delay
    ol_flag = 1'b1;
    wait_ticks(DLY, 1'b0);
    chk("R2 no fault during delay", lp_fault, 1'b0);
    chk("R2 triggers free", trig_gate, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 lp_fault", lp_fault, 1'b1);
    chk("R6 ol_fault", ol_fault, 1'b1);
    chk("R6 ot_fault", ot_fault, 1'b0);
    chk("R6 trig_gate", trig_gate, 1'b1);
    chk("R6 turnoff", turnoff, 1'b1);
    ol_flag = 1'b0;
    wait_ticks(3, 1'b0);
    chk("R6 held", lp_fault, 1'b1);

    // R7: supply collapse
    sup_lo = 1'b1;
    #1;
    chk("R7 turnoff drops", turnoff, 1'b0);
    ov_flag = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 fault cleared", lp_fault, 1'b0);
    chk("R7 ov ignored", sw_force, 1'b0);
    chk("R7 gate low", trig_gate, 1'b0);
    sup_lo = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 still down", ov_active, 1'b0);
    ov_flag = 1'b0;
    sup_ok = 1'b1;
    @(negedge clk);
    sup_ok = 1'b0;
    @(negedge clk);
    chk("R7 restart clean", trig_gate, 1'b0);

    // R3: missed re-check window, then proper re-check
    pcycle();
    ol_start(DLY + 2);
    ol_start(DLY + 1);
    chk("R3 missed window no latch", lp_fault, 1'b0);
    ol_pulse();
    chk("R3 re-check latches", ol_fault, 1'b1);

    // R5: overtemperature
    pcycle();
    ot_flag = 1'b1;
    wait_ticks(DLY, 1'b0);
    chk("R5 no early ot", lp_fault, 1'b0);
    repeat (2) @(negedge clk);
    chk("R5 ot_fault", ot_fault, 1'b1);
    chk("R5 ol_fault clear", ol_fault, 1'b0);
    ot_flag = 1'b0;

    // R12: overvoltage during latched fault
    ov_flag = 1'b1;
    repeat (FILT + 1) @(negedge clk);
    ov_flag = 1'b0;
    chk("R12 ov_active", ov_active, 1'b1);
    chk("R12 no force", sw_force, 1'b0);
    pcycle();

    // R4 directed corners then random
    blank_trial(1'b1, BLK);
    blank_trial(1'b1, BLK + 1);
    blank_trial(1'b0, 0);
    for (int i = 0; i < 12; i++)
      blank_trial(1'($urandom_range(0, 1)), int'($urandom_range(0, 8)));
    pcycle();

    // R9 / R10: directed overvoltage timing
    ov_flag = 1'b1;
    repeat (FILT - 1) @(negedge clk);
    chk("R8 not yet", ov_active, 1'b0);
    @(negedge clk);
    ov_flag = 1'b0;
    chk("R9 force on", sw_force, 1'b1);
    chk("R10 gate on", trig_gate, 1'b1);
    wait_ticks(FRC, 1'b1);
    chk("R9 force held", sw_force, 1'b1);
    @(negedge clk);
    chk("R9 force ends", sw_force, 1'b0);
    chk("R10 gate held", trig_gate, 1'b1);
    wait_ticks(OVT - FRC, 1'b0);
    chk("R10 ov held", ov_active, 1'b1);
    @(negedge clk);
    chk("R10 ov ends", ov_active, 1'b0);
    chk("R10 gate ends", trig_gate, 1'b0);

    // R11: overvoltage inside and outlasting the window
    zc_win = 1'b1;
    ov_flag = 1'b1;
    repeat (10) @(negedge clk);
    zc_win = 1'b0;
    ov_flag = 1'b0;
    @(negedge clk);
    chk("R11 window ov ignored", ov_active, 1'b0);
    zc_win = 1'b1;
    ov_flag = 1'b1;
    repeat (6) @(negedge clk);
    zc_win = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    chk("R11 filter restarts", ov_active, 1'b0);
    @(negedge clk);
    chk("R11 ov after window", ov_active, 1'b1);
    ov_flag = 1'b0;
    wait_ticks(OVT + 1, 1'b0);
    @(negedge clk);

    // R8 random pulse lengths
    ov_trial(FILT - 1);
    ov_trial(FILT);
    for (int i = 0; i < 16; i++)
      ov_trial(int'($urandom_range(1, 2 * FILT)));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule